// File: doc/BRIEF.md
# Dual Interval Timer with Interrupt Unit

This block holds two independent down-counting interval timers behind a 32-bit word-addressed register port. Each timer has a reload value, a control word and a live count that can be read back. The control word combines an operation code (load, hold, run) with a tick-source code. The tick sources are enable pulses generated elsewhere in the chip. A running timer steps down by one on each cycle in which its chosen pulse is high, and reloads itself at the end of each period.

Each period end sets one bit in a shared raw status word. Software enables bits through a mask word and clears them by writing ones to an acknowledge offset. The masked status can be read, and a single level interrupt output is high while any masked bit is set. Reads are registered: the data for a read issued in one cycle appears on the read bus in the next cycle and is held until the next read.

Top module: `dit_top`

## Requirements
- R1: Offsets (byte addresses) are: timer0 reload 0x00, timer0 count 0x04, timer0 control 0x08, timer1 reload 0x10, timer1 count 0x14, timer1 control 0x18, mask 0x48, acknowledge 0x4C, raw status 0x50, masked status 0x54. A read returns the count, mask, raw status or masked status on `bus_rdata` in the cycle after `bus_rd`, zero-extended to 32 bits. Other offsets read as 0. `bus_rdata` holds its value when no read is issued.
- R2: A control write with bits [1:0] = 0 (load) copies the reload value into the counter and leaves the running or held state unchanged.
- R3: A control write with bits [1:0] = 1 (hold) stops the counter, and a held counter keeps its value. Code 3 changes neither the counter nor the running state.
- R4: A control write with bits [1:0] = 2 (run) starts the counter. A running counter decrements by one in each cycle where the tick pulse chosen by control bits [4:2] is high. Source code c in the range 4 to 7 selects `tick_en[c-4]`.
- R5: Source codes 0 to 3 select no pulse, so the counter does not advance.
- R6: A tick that arrives while the count is 1 or less reloads the counter from the reload value, giving a period of N ticks for a reload value of N. At that point timer0 sets raw status bit 0 and timer1 sets raw status bit 1.
- R7: A write to a reload register does not change the count. The new value is used at the next load operation or the next reload.
- R8: Writing the acknowledge offset clears each raw status bit written as 1 and leaves the bits written as 0. The acknowledge value is not stored, so later period ends set their bits again.
- R9: Masked status equals raw status AND mask (mask bits [1:0]). `irq_o` is high exactly when masked status is nonzero, and it changes at the same clock edge as the status or mask change that causes it.
- R10: If a period end and an acknowledge of the same bit occur in the same cycle, the bit ends up set.
- R11: Writes to the count offsets are ignored.
- R12: A synchronous reset sets both counters to 0, holds both timers with source code 0, clears the raw status and mask, and drives `irq_o` low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 8 | Byte offset of the access |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 32 | Write data |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 32 | Read data, valid the cycle after `bus_rd` |
| tick_en | input | 4 | Per-source tick enable pulses |
| irq_o | output | 1 | Level interrupt, OR of masked status |

## Verification
Every state change lands at the clock edge that samples the write or tick. The count, status and mask are therefore visible one edge after their stimulus. `irq_o` is computed from next-state values, so it also moves at that same edge and not one cycle later. Read data arrives one edge after the strobe and shows the state from before that edge. The bench therefore keeps each stimulus and the read that observes it in separate cycles. It drives each vector for one cycle on the falling edge and compares `bus_rdata` and `irq_o` at the next falling edge, one register stage after the stimulus.

// File: rtl/dit_pkg.sv
package dit_pkg;
  typedef enum logic [1:0] {
    OP_LOAD = 2'd0,
    OP_HOLD = 2'd1,
    OP_RUN  = 2'd2,
    OP_NOP  = 2'd3
  } op_e;

  localparam int SRC_W      = 3;
  localparam int SRC_LSB    = 2;
  localparam int SRC_BASE   = 4;
  localparam int TMR_STRIDE = 'h10;
  localparam int OFF_DIV    = 'h00;
  localparam int OFF_CNT    = 'h04;
  localparam int OFF_CTRL   = 'h08;
  localparam int OFF_MASK   = 'h48;
  localparam int OFF_ACK    = 'h4C;
  localparam int OFF_STAT   = 'h50;
  localparam int OFF_MSTAT  = 'h54;
endpackage

// File: rtl/dit_timer.sv
module dit_timer
  import dit_pkg::*;
#(
  parameter int CNT_W   = 32,
  parameter int NUM_SRC = 4,
  parameter int DATA_W  = 32
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               div_we,
  input  logic               ctrl_we,
  input  logic [DATA_W-1:0]  wdata,
  input  logic [NUM_SRC-1:0] tick_en,
  output logic [CNT_W-1:0]   cnt_o,
  output logic               expire_o
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] div_q;
  logic [CNT_W-1:0] cnt_q;
  logic [SRC_W-1:0] src_q;
  logic             run_q;
  logic             tick_sel;
  logic             step;
  op_e              op_w;

  assign op_w = op_e'(wdata[1:0]);

  always_comb begin
    tick_sel = 1'b0;
    for (int k = 0; k < NUM_SRC; k++) begin
      if (src_q == SRC_W'(SRC_BASE + k)) tick_sel = tick_en[k];
    end
  end

  assign step     = run_q && tick_sel && !ctrl_we;
  assign expire_o = step && (cnt_q <= ONE);
  assign cnt_o    = cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      div_q <= '0;
      cnt_q <= '0;
      src_q <= '0;
      run_q <= 1'b0;
    end else begin
      if (div_we) div_q <= wdata[CNT_W-1:0];
      if (ctrl_we) begin
        src_q <= wdata[SRC_LSB +: SRC_W];
        case (op_w)
          OP_LOAD: cnt_q <= div_q;
          OP_HOLD: run_q <= 1'b0;
          OP_RUN:  run_q <= 1'b1;
          default: ;
        endcase
      end else if (step) begin
        if (cnt_q <= ONE) cnt_q <= div_q;
        else              cnt_q <= cnt_q - ONE;
      end
    end
  end

  p_hold_stable_r3: assert property (@(posedge clk) disable iff (rst)
    (!run_q && !ctrl_we) |=> $stable(cnt_q));
  p_decrement_r4: assert property (@(posedge clk) disable iff (rst)
    (run_q && tick_sel && !ctrl_we && cnt_q > ONE) |=> (cnt_q == $past(cnt_q) - ONE));
  p_reload_r6: assert property (@(posedge clk) disable iff (rst)
    expire_o |=> (cnt_q == $past(div_q)));
endmodule

// File: rtl/dit_irq.sv
module dit_irq #(
  parameter int N = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] set_i,
  input  logic         mask_we,
  input  logic         ack_we,
  input  logic [N-1:0] wbits,
  output logic [N-1:0] stat_o,
  output logic [N-1:0] mask_o,
  output logic         irq_o
);
  logic [N-1:0] stat_q, mask_q, stat_d, mask_d, clr;
  logic         irq_q;

  assign clr    = ack_we ? wbits : '0;
  assign stat_d = (stat_q & ~clr) | set_i;
  assign mask_d = mask_we ? wbits : mask_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      stat_q <= '0;
      mask_q <= '0;
      irq_q  <= 1'b0;
    end else begin
      stat_q <= stat_d;
      mask_q <= mask_d;
      irq_q  <= |(stat_d & mask_d);
    end
  end

  assign stat_o = stat_q;
  assign mask_o = mask_q;
  assign irq_o  = irq_q;

  p_irq_match_r9: assert property (@(posedge clk) disable iff (rst)
    irq_o == (|(stat_q & mask_q)));
  p_set_wins_r10: assert property (@(posedge clk) disable iff (rst)
    (set_i != '0) |=> ((stat_q & $past(set_i)) == $past(set_i)));
  p_ack_clears_r8: assert property (@(posedge clk) disable iff (rst)
    ((clr & ~set_i) != '0) |=> ((stat_q & $past(clr & ~set_i)) == '0));
endmodule

// File: rtl/dit_top.sv
module dit_top
  import dit_pkg::*;
#(
  parameter int ADDR_W  = 8,
  parameter int DATA_W  = 32,
  parameter int CNT_W   = 32,
  parameter int NUM_SRC = 4,
  parameter int NUM_TMR = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic               bus_wr,
  input  logic [DATA_W-1:0]  bus_wdata,
  input  logic               bus_rd,
  output logic [DATA_W-1:0]  bus_rdata,
  input  logic [NUM_SRC-1:0] tick_en,
  output logic               irq_o
);
  logic [CNT_W-1:0]   cnt_arr [NUM_TMR];
  logic [NUM_TMR-1:0] expire;
  logic [NUM_TMR-1:0] stat, mask;
  logic [DATA_W-1:0]  rd_d;
  logic [DATA_W-1:0]  rdata_q;

  for (genvar i = 0; i < NUM_TMR; i++) begin : g_tmr
    logic div_we, ctrl_we;
    assign div_we  = bus_wr && (bus_addr == ADDR_W'(i*TMR_STRIDE + OFF_DIV));
    assign ctrl_we = bus_wr && (bus_addr == ADDR_W'(i*TMR_STRIDE + OFF_CTRL));
    dit_timer #(.CNT_W(CNT_W), .NUM_SRC(NUM_SRC), .DATA_W(DATA_W)) u_tmr (
      .clk      (clk),
      .rst      (rst),
      .div_we   (div_we),
      .ctrl_we  (ctrl_we),
      .wdata    (bus_wdata),
      .tick_en  (tick_en),
      .cnt_o    (cnt_arr[i]),
      .expire_o (expire[i])
    );
  end

  dit_irq #(.N(NUM_TMR)) u_irq (
    .clk     (clk),
    .rst     (rst),
    .set_i   (expire),
    .mask_we (bus_wr && (bus_addr == ADDR_W'(OFF_MASK))),
    .ack_we  (bus_wr && (bus_addr == ADDR_W'(OFF_ACK))),
    .wbits   (bus_wdata[NUM_TMR-1:0]),
    .stat_o  (stat),
    .mask_o  (mask),
    .irq_o   (irq_o)
  );

  always_comb begin
    rd_d = '0;
    for (int i = 0; i < NUM_TMR; i++) begin
      if (bus_addr == ADDR_W'(i*TMR_STRIDE + OFF_CNT)) rd_d = DATA_W'(cnt_arr[i]);
    end
    if (bus_addr == ADDR_W'(OFF_MASK))  rd_d = DATA_W'(mask);
    if (bus_addr == ADDR_W'(OFF_STAT))  rd_d = DATA_W'(stat);
    if (bus_addr == ADDR_W'(OFF_MSTAT)) rd_d = DATA_W'(stat & mask);
  end

  always_ff @(posedge clk) begin
    if (rst)         rdata_q <= '0;
    else if (bus_rd) rdata_q <= rd_d;
  end

  assign bus_rdata = rdata_q;

  p_rdata_hold_r1: assert property (@(posedge clk) disable iff (rst)
    !bus_rd |=> $stable(bus_rdata));
endmodule

// File: tb/dit_top_tb.sv
module dit_top_tb;
  localparam int VW = 83;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic        bus_rd = 1'b0;
  logic [31:0] bus_rdata;
  logic [3:0]  tick_en = '0;
  logic        irq_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  dit_top u_dut (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
    .tick_en(tick_en), .irq_o(irq_o)
  );

  // {req, wr, rd, addr, data, tick, exp_rdata, exp_irq}
  function automatic logic [VW-1:0] mk(int rq, bit w, bit r, logic [7:0] a,
      logic [31:0] d, logic [3:0] t, logic [31:0] e, bit q);
    return {4'(rq), w, r, a, d, t, e, q};
  endfunction
  function automatic logic [VW-1:0] vw(int rq, logic [7:0] a, logic [31:0] d, bit q);
    return mk(rq, 1'b1, 1'b0, a, d, 4'h0, 32'h0, q);
  endfunction
  function automatic logic [VW-1:0] vr(int rq, logic [7:0] a, logic [31:0] e, bit q);
    return mk(rq, 1'b0, 1'b1, a, 32'h0, 4'h0, e, q);
  endfunction
  function automatic logic [VW-1:0] vt(int rq, logic [3:0] t, bit q);
    return mk(rq, 1'b0, 1'b0, 8'h0, 32'h0, t, 32'h0, q);
  endfunction

  localparam int NV = 51;
  localparam logic [VW-1:0] VEC [NV] = '{
    vr(12, 8'h04, 32'd0, 1'b0),          // R12 count after reset
    vr(12, 8'h48, 32'd0, 1'b0),          // R12 mask after reset
    vr(12, 8'h50, 32'd0, 1'b0),          // R12 status after reset
    vw(1,  8'h00, 32'd3, 1'b0),          // R1 reload0 = 3
    vw(2,  8'h08, 32'h10, 1'b0),         // R2 load, source 4
    vr(2,  8'h04, 32'd3, 1'b0),          // R2 count = 3
    vw(4,  8'h08, 32'h12, 1'b0),         // R4 run
    vt(4,  4'b0001, 1'b0),               // R4 tick
    vr(4,  8'h04, 32'd2, 1'b0),          // R4 count 2
    vt(4,  4'b0010, 1'b0),               // R4 other source
    vr(4,  8'h04, 32'd2, 1'b0),          // R4 unchanged
    vt(4,  4'b0001, 1'b0),
    vt(6,  4'b0001, 1'b0),               // R6 period end, mask 0
    vr(6,  8'h50, 32'd1, 1'b0),          // R6 status bit0
    vr(9,  8'h54, 32'd0, 1'b0),          // R9 masked 0
    vw(9,  8'h48, 32'd1, 1'b1),          // R9 mask -> irq same edge
    vr(9,  8'h54, 32'd1, 1'b1),          // R9 masked 1
    vr(6,  8'h04, 32'd3, 1'b1),          // R6 reloaded
    vw(8,  8'h4C, 32'd2, 1'b1),          // R8 ack other bit
    vr(8,  8'h50, 32'd1, 1'b1),          // R8 bit0 kept
    vw(8,  8'h4C, 32'd1, 1'b0),          // R8 ack bit0
    vr(8,  8'h50, 32'd0, 1'b0),          // R8 cleared
    vw(3,  8'h08, 32'h11, 1'b0),         // R3 hold
    vt(3,  4'b0001, 1'b0),
    vr(3,  8'h04, 32'd3, 1'b0),          // R3 held
    vw(7,  8'h00, 32'd5, 1'b0),          // R7 new reload
    vr(7,  8'h04, 32'd3, 1'b0),          // R7 count untouched
    vw(2,  8'h08, 32'h10, 1'b0),         // R2 load while held
    vr(2,  8'h04, 32'd5, 1'b0),          // R2 count = 5
    vt(2,  4'b0001, 1'b0),               // R2 still held
    vr(2,  8'h04, 32'd5, 1'b0),
    vw(1,  8'h10, 32'd2, 1'b0),          // R1 reload1 = 2
    vw(2,  8'h18, 32'h1C, 1'b0),         // R2 load, source 7
    vw(4,  8'h18, 32'h1E, 1'b0),         // R4 run
    vt(4,  4'b1000, 1'b0),
    vt(6,  4'b1000, 1'b0),               // R6 timer1 end, masked off
    vr(6,  8'h50, 32'd2, 1'b0),          // R6 status bit1
    vr(9,  8'h54, 32'd0, 1'b0),
    vw(9,  8'h48, 32'd3, 1'b1),          // R9
    vr(9,  8'h54, 32'd2, 1'b1),
    vw(5,  8'h18, 32'h06, 1'b1),         // R5 run on source 1
    vt(5,  4'b1111, 1'b1),
    vr(5,  8'h14, 32'd2, 1'b1),          // R5 no advance
    vw(11, 8'h14, 32'h55, 1'b1),         // R11 write to count
    vr(11, 8'h14, 32'd2, 1'b1),          // R11 ignored
    vw(8,  8'h4C, 32'd2, 1'b0),          // R8
    vw(4,  8'h18, 32'h1E, 1'b0),
    vt(4,  4'b1000, 1'b0),
    mk(10, 1'b1, 1'b0, 8'h4C, 32'd2, 4'b1000, 32'd0, 1'b1), // R10 set and ack together
    vr(10, 8'h50, 32'd2, 1'b1),          // R10 set wins
    vr(6,  8'h14, 32'd2, 1'b1)           // R6 reloaded
  };

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic idle();
    bus_wr = 1'b0; bus_rd = 1'b0; bus_addr = '0; bus_wdata = '0; tick_en = '0;
  endtask

  task automatic rd_chk(string tag, logic [7:0] a, logic [31:0] e);
    bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    idle();
    check(tag, bus_rdata, e);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    check("R12 irq after reset", 32'(irq_o), 32'd0);
    for (int i = 0; i < NV; i++) begin
      logic [VW-1:0] v;
      v = VEC[i];
      bus_wr = v[78]; bus_rd = v[77]; bus_addr = v[76:69];
      bus_wdata = v[68:37]; tick_en = v[36:33];
      @(negedge clk);
      idle();
      if (v[77]) check($sformatf("R%0d vector %0d rdata", v[82:79], i), bus_rdata, v[32:1]);
      check($sformatf("R%0d vector %0d irq", v[82:79], i), 32'(irq_o), 32'(v[0]));
    end
    // R12: reset in the middle of activity (irq high, timer1 running)
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    check("R12 irq low after reset", 32'(irq_o), 32'd0);
    rd_chk("R12 mask cleared", 8'h48, 32'd0);
    rd_chk("R12 status cleared", 8'h50, 32'd0);
    rd_chk("R12 count1 zero", 8'h14, 32'd0);
    tick_en = 4'hF;
    @(negedge clk);
    idle();
    rd_chk("R12 timers stopped", 8'h50, 32'd0);
    rd_chk("R1 unmapped offset reads zero", 8'h3C, 32'd0);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule